// File: doc/BRIEF.md
# Linked-List DMA Descriptor Walker

This block is a single DMA channel engine. It walks a chain of descriptor elements held in a local descriptor memory. Each data element names a source address, a destination address and a byte count. For every data element it owns, the engine issues one transfer request carrying these fields and waits for the mover to answer. Link elements redirect the walk to a new element address. A link can also invert the engine's consumer cycle state.

Ownership works through a cycle bit in each element. The engine executes a data element only when that element's cycle bit equals its own consumer cycle state. A mismatch means the producer has not yet filled that slot. The engine then parks on that element and waits for the next doorbell. A link back to the head that flips the consumer state lets software reuse one ring of descriptors lap after lap, because producer and consumer agree on ownership by alternating the cycle-bit value. Software never has to clear ownership fields.

Software programs the 64-bit list pointer as two 32-bit halves. It sets the consumer state through a cycle-sync strobe, then rings the doorbell. The engine reports the completion of flagged elements as one-cycle events, one for the local side and one for the remote side. It reports a failed transfer as a one-cycle abort event.

Top module: `ll_dma_walker`

## Requirements
- R1: After reset the engine is idle, with busy, consumer cycle state, descriptor reads, transfer request and all event outputs at 0, and the list pointer at 0.
- R2: While idle, a low-half write loads pointer bits 31:0 and a high-half write loads bits 63:32. A doorbell starts the walk at the element at that byte address (descriptor word address = pointer bits DESC_AW+1:2). Pointer writes while busy are ignored.
- R3: A cycle-sync strobe while idle sets the consumer cycle state to 1.
- R4: A data element is six 32-bit words at increasing addresses: control, size, source low, source high, destination low, destination high. Elements follow each other every 24 bytes. The transfer request carries these fields and stays asserted with stable fields until done or error is returned.
- R5: A data element whose control bit 0 (cycle bit) differs from the consumer cycle state is not executed. The engine drops busy, keeps the pointer on that element, and the next doorbell resumes there.
- R6: An element with control bit 2 set is a link. Its words 2 and 3 hold the low and high halves of the next element pointer, and the walk continues there. The cycle bit of a link is not checked.
- R7: A link with control bit 1 set inverts the consumer cycle state. The state changes at no other time while busy.
- R8: When a data element with control bit 3 set completes, done_local_o pulses for exactly one cycle.
- R9: When a data element with control bit 4 set completes while remote_i is 1, done_remote_o pulses for exactly one cycle. It does not pulse when remote_i is 0.
- R10: A transfer error raises abort_o for one cycle and returns the engine to idle, with the pointer still on the failed element. Error takes precedence over a done in the same cycle, and no completion event is raised.
- R11: A doorbell while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| llp_lo_we_i | input | 1 | Write low half of list pointer |
| llp_hi_we_i | input | 1 | Write high half of list pointer |
| llp_wdata_i | input | 32 | Pointer half write data |
| cycle_sync_i | input | 1 | Set consumer cycle state to 1 |
| doorbell_i | input | 1 | Start or resume the walk |
| remote_i | input | 1 | Remote mode enable for remote done event |
| desc_rd_o | output | 1 | Descriptor memory read strobe |
| desc_addr_o | output | DESC_AW | Descriptor word address |
| desc_rdata_i | input | 32 | Read data, valid the cycle after the strobe |
| xfer_req_o | output | 1 | Transfer request |
| xfer_src_o | output | 64 | Source address |
| xfer_dst_o | output | 64 | Destination address |
| xfer_size_o | output | 32 | Byte count |
| xfer_done_i | input | 1 | Transfer completed |
| xfer_err_i | input | 1 | Transfer failed |
| done_local_o | output | 1 | Local completion event |
| done_remote_o | output | 1 | Remote completion event |
| abort_o | output | 1 | Abort event |
| busy_o | output | 1 | Engine walking |
| ccs_o | output | 1 | Consumer cycle state |

## Verification
The assertions assume that the mover raises done or error only while a request is pending. They also assume that the descriptor memory is not rewritten while the engine is busy, and that cycle-sync is strobed only between walks. The bench keeps to these rules: its responder answers only a request it has seen, and it rebuilds rings only after busy has dropped. It sweeps ring lengths of one to four elements in both modes over two laps with alternating cycle-bit values. It then injects a stall at the head, an error mid-ring, and pointer and doorbell writes during a walk.

// File: rtl/ll_dma_pkg.sv
package ll_dma_pkg;
  localparam int CTL_CB  = 0;
  localparam int CTL_TCB = 1;
  localparam int CTL_LLP = 2;
  localparam int CTL_LIE = 3;
  localparam int CTL_RIE = 4;
  localparam int ELEM_WORDS = 6;
  localparam logic [63:0] ELEM_BYTES = 64'd24;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HEAD, ST_LINK, ST_BODY, ST_XFER
  } walk_st_e;
endpackage

// File: rtl/ll_dma_fetch.sv
module ll_dma_fetch #(
  parameter int DESC_AW = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [2:0]           first_i,
  input  logic [2:0]           last_i,
  input  logic [DESC_AW-1:0]   base_i,
  output logic                 desc_rd_o,
  output logic [DESC_AW-1:0]   desc_addr_o,
  input  logic [31:0]          desc_rdata_i,
  output logic                 done_o,
  output logic [ll_dma_pkg::ELEM_WORDS-1:0][31:0] words_o
);
  import ll_dma_pkg::*;

  logic       active_q, phase_q, done_q;
  logic [2:0] idx_q, last_q;
  logic [ELEM_WORDS-1:0][31:0] words_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      phase_q  <= 1'b0;
      done_q   <= 1'b0;
      idx_q    <= '0;
      last_q   <= '0;
      words_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        active_q <= 1'b1;
        phase_q  <= 1'b0;
        idx_q    <= first_i;
        last_q   <= last_i;
      end else if (active_q) begin
        if (!phase_q) begin
          phase_q <= 1'b1;
        end else begin
          // read data returned one cycle after the strobe
          words_q[idx_q] <= desc_rdata_i;
          phase_q <= 1'b0;
          if (idx_q == last_q) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end else begin
            idx_q <= idx_q + 3'd1;
          end
        end
      end
    end
  end

  assign desc_rd_o   = active_q & ~phase_q;
  assign desc_addr_o = base_i + DESC_AW'(idx_q);
  assign done_o      = done_q;
  assign words_o     = words_q;

  a_r4_start_when_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !active_q);
  a_r4_read_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_rd_o |=> !desc_rd_o);
endmodule

// File: rtl/ll_dma_ctx.sv
module ll_dma_ctx #(
  parameter int DESC_AW = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               idle_i,
  input  logic               lo_we_i,
  input  logic               hi_we_i,
  input  logic [31:0]        wdata_i,
  input  logic               sync_i,
  input  logic               link_ld_i,
  input  logic [63:0]        link_ptr_i,
  input  logic               tog_i,
  input  logic               adv_i,
  output logic [DESC_AW-1:0] base_o,
  output logic               ccs_o
);
  import ll_dma_pkg::*;

  logic [63:0] ptr_q;
  logic        ccs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (link_ld_i) begin
      ptr_q <= link_ptr_i;
    end else if (adv_i) begin
      ptr_q <= ptr_q + ELEM_BYTES;
    end else if (idle_i) begin
      if (lo_we_i) ptr_q[31:0]  <= wdata_i;
      if (hi_we_i) ptr_q[63:32] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ccs_q <= 1'b0;
    else if (idle_i && sync_i) ccs_q <= 1'b1;
    else if (tog_i)           ccs_q <= ~ccs_q;
  end

  assign base_o = ptr_q[DESC_AW+1:2];
  assign ccs_o  = ccs_q;

  a_r2_ptr_frozen_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_i && !link_ld_i && !adv_i |=> $stable(ptr_q));
  a_r10_no_adv_and_link: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(link_ld_i && adv_i));
endmodule

// File: rtl/ll_dma_walker.sv
module ll_dma_walker #(
  parameter int DESC_AW = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               llp_lo_we_i,
  input  logic               llp_hi_we_i,
  input  logic [31:0]        llp_wdata_i,
  input  logic               cycle_sync_i,
  input  logic               doorbell_i,
  input  logic               remote_i,
  output logic               desc_rd_o,
  output logic [DESC_AW-1:0] desc_addr_o,
  input  logic [31:0]        desc_rdata_i,
  output logic               xfer_req_o,
  output logic [63:0]        xfer_src_o,
  output logic [63:0]        xfer_dst_o,
  output logic [31:0]        xfer_size_o,
  input  logic               xfer_done_i,
  input  logic               xfer_err_i,
  output logic               done_local_o,
  output logic               done_remote_o,
  output logic               abort_o,
  output logic               busy_o,
  output logic               ccs_o
);
  import ll_dma_pkg::*;

  walk_st_e state_q, state_d;
  logic       f_start, f_done;
  logic [2:0] f_first, f_last;
  logic [ELEM_WORDS-1:0][31:0] words;
  logic [DESC_AW-1:0] base;
  logic       ccs;
  logic       link_ld, tog, adv, ev_done, ev_abort;
  logic [31:0] ctl;
  logic       done_l_q, done_r_q, abort_q;
  logic       unused_ctl;

  assign ctl        = words[0];
  assign unused_ctl = ^ctl[31:5];

  ll_dma_ctx #(.DESC_AW(DESC_AW)) ctx_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .idle_i     (state_q == ST_IDLE),
    .lo_we_i    (llp_lo_we_i),
    .hi_we_i    (llp_hi_we_i),
    .wdata_i    (llp_wdata_i),
    .sync_i     (cycle_sync_i),
    .link_ld_i  (link_ld),
    .link_ptr_i ({words[3], words[2]}),
    .tog_i      (tog),
    .adv_i      (adv),
    .base_o     (base),
    .ccs_o      (ccs)
  );

  ll_dma_fetch #(.DESC_AW(DESC_AW)) fetch_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (f_start),
    .first_i      (f_first),
    .last_i       (f_last),
    .base_i       (base),
    .desc_rd_o    (desc_rd_o),
    .desc_addr_o  (desc_addr_o),
    .desc_rdata_i (desc_rdata_i),
    .done_o       (f_done),
    .words_o      (words)
  );

  always_comb begin
    state_d  = state_q;
    f_start  = 1'b0;
    f_first  = 3'd0;
    f_last   = 3'd0;
    link_ld  = 1'b0;
    tog      = 1'b0;
    adv      = 1'b0;
    ev_done  = 1'b0;
    ev_abort = 1'b0;
    unique case (state_q)
      ST_IDLE: if (doorbell_i) begin
        f_start = 1'b1;
        state_d = ST_HEAD;
      end
      ST_HEAD: if (f_done) begin
        if (ctl[CTL_LLP]) begin
          f_start = 1'b1;
          f_first = 3'd2;
          f_last  = 3'd3;
          state_d = ST_LINK;
        end else if (ctl[CTL_CB] != ccs) begin
          state_d = ST_IDLE;   // not owned: park on this element
        end else begin
          f_start = 1'b1;
          f_first = 3'd1;
          f_last  = 3'd5;
          state_d = ST_BODY;
        end
      end
      ST_LINK: if (f_done) begin
        link_ld = 1'b1;
        tog     = ctl[CTL_TCB];
        f_start = 1'b1;
        state_d = ST_HEAD;
      end
      ST_BODY: if (f_done) state_d = ST_XFER;
      ST_XFER: begin
        if (xfer_err_i) begin
          ev_abort = 1'b1;
          state_d  = ST_IDLE;
        end else if (xfer_done_i) begin
          ev_done = 1'b1;
          adv     = 1'b1;
          f_start = 1'b1;
          state_d = ST_HEAD;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      done_l_q <= 1'b0;
      done_r_q <= 1'b0;
      abort_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      done_l_q <= ev_done & ctl[CTL_LIE];
      done_r_q <= ev_done & ctl[CTL_RIE] & remote_i;
      abort_q  <= ev_abort;
    end
  end

  assign xfer_req_o    = (state_q == ST_XFER);
  assign xfer_size_o   = words[1];
  assign xfer_src_o    = {words[3], words[2]};
  assign xfer_dst_o    = {words[5], words[4]};
  assign done_local_o  = done_l_q;
  assign done_remote_o = done_r_q;
  assign abort_o       = abort_q;
  assign busy_o        = (state_q != ST_IDLE);
  assign ccs_o         = ccs;

  a_r4_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_o && !xfer_done_i && !xfer_err_i |=>
      xfer_req_o && $stable(xfer_src_o) && $stable(xfer_dst_o) && $stable(xfer_size_o));
  a_r10_abort_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> !busy_o);
  a_r10_abort_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_local_o, abort_o}));
  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_local_o |=> !done_local_o);
  a_r9_remote_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_remote_o |-> $past(remote_i));
  a_r7_ccs_only_link: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_LINK) && !cycle_sync_i |=> $stable(ccs_o));
endmodule

// File: tb/ll_dma_walker_tb_top.sv
module ll_dma_walker_tb_top;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic llp_lo_we = 0, llp_hi_we = 0, cycle_sync = 0, doorbell = 0, remote = 0;
  logic [31:0] llp_wdata = '0;
  logic desc_rd;
  logic [AW-1:0] desc_addr;
  logic [31:0] rdata_q = '0;
  logic xfer_req, xfer_done = 0, xfer_err = 0;
  logic [63:0] xfer_src, xfer_dst;
  logic [31:0] xfer_size;
  logic done_local, done_remote, abort_ev, busy, ccs;

  ll_dma_walker #(.DESC_AW(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .llp_lo_we_i(llp_lo_we), .llp_hi_we_i(llp_hi_we), .llp_wdata_i(llp_wdata),
    .cycle_sync_i(cycle_sync), .doorbell_i(doorbell), .remote_i(remote),
    .desc_rd_o(desc_rd), .desc_addr_o(desc_addr), .desc_rdata_i(rdata_q),
    .xfer_req_o(xfer_req), .xfer_src_o(xfer_src), .xfer_dst_o(xfer_dst),
    .xfer_size_o(xfer_size), .xfer_done_i(xfer_done), .xfer_err_i(xfer_err),
    .done_local_o(done_local), .done_remote_o(done_remote), .abort_o(abort_ev),
    .busy_o(busy), .ccs_o(ccs)
  );

  logic [31:0] mem [256];
  always @(posedge clk) if (desc_rd) rdata_q <= mem[desc_addr];

  int checks = 0, errors = 0;
  int n_dl = 0, n_dr = 0, n_ab = 0, n_xfer = 0;
  int xi = 0, cur_n = 1, delay = 0, err_idx = 0;
  bit err_arm = 0;
  logic [31:0] cur_base = '0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] e_src(logic [31:0] b, int n, int i);
    return {32'hA0 + 32'(n), b + 32'(i) * 32'h40};
  endfunction
  function automatic logic [63:0] e_dst(logic [31:0] b, int n, int i);
    return {32'hB0 + 32'(n), 32'h2000_0000 + b + 32'(i) * 32'h80};
  endfunction
  function automatic logic [31:0] e_size(int n, int i);
    return 32'h100 + 32'(i) * 32'd16 + 32'(n);
  endfunction

  always @(negedge clk) if (rst_n) begin
    if (done_local)  n_dl++;
    if (done_remote) n_dr++;
    if (abort_ev)    n_ab++;
  end

  // transfer responder: R4 field check per request
  initial begin
    forever begin
      @(negedge clk);
      if (xfer_req) begin
        chk(xfer_src == e_src(cur_base, cur_n, xi % cur_n), "R4 src", xfer_src, e_src(cur_base, cur_n, xi % cur_n));
        chk(xfer_dst == e_dst(cur_base, cur_n, xi % cur_n), "R4 dst", xfer_dst, e_dst(cur_base, cur_n, xi % cur_n));
        chk(xfer_size == e_size(cur_n, xi % cur_n), "R4 size", 64'(xfer_size), 64'(e_size(cur_n, xi % cur_n)));
        repeat (delay) @(negedge clk);
        n_xfer++;
        if (err_arm && xi == err_idx) begin
          err_arm = 0;
          xfer_err = 1;
          xfer_done = 1;
        end else begin
          xfer_done = 1;
          xi++;
        end
        @(negedge clk);
        xfer_done = 0;
        xfer_err = 0;
      end
    end
  end

  task automatic build_ring(input logic [31:0] b, input int n, input bit cb);
    for (int i = 0; i < n; i++) begin
      int w = int'((b + 32'(i) * 32'd24) >> 2);
      logic [63:0] s = e_src(b, n, i);
      logic [63:0] d = e_dst(b, n, i);
      mem[w]   = {27'd0, (i == n - 1) ? 2'b11 : 2'b00, 2'b00, cb};
      mem[w+1] = e_size(n, i);
      mem[w+2] = s[31:0];
      mem[w+3] = s[63:32];
      mem[w+4] = d[31:0];
      mem[w+5] = d[63:32];
    end
    begin
      int w = int'((b + 32'(n) * 32'd24) >> 2);
      mem[w]   = 32'h6;  // link + toggle
      mem[w+1] = '0;
      mem[w+2] = b;
      mem[w+3] = '0;
    end
  endtask

  task automatic pulse_ptr(input logic [31:0] lo, input logic [31:0] hi);
    llp_lo_we = 1; llp_wdata = lo; @(negedge clk);
    llp_lo_we = 0; llp_hi_we = 1; llp_wdata = hi; @(negedge clk);
    llp_hi_we = 0;
  endtask
  task automatic pulse_sync();
    cycle_sync = 1; @(negedge clk); cycle_sync = 0;
  endtask
  task automatic pulse_bell();
    doorbell = 1; @(negedge clk); doorbell = 0;
  endtask
  task automatic wait_idle();
    int g = 0;
    @(negedge clk);
    while (busy && g < 20000) begin @(negedge clk); g++; end
    repeat (2) @(negedge clk);
  endtask
  task automatic clr();
    n_dl = 0; n_dr = 0; n_ab = 0; n_xfer = 0; xi = 0;
  endtask
  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !ccs && !xfer_req && !desc_rd, "R1 idle", {busy, ccs, xfer_req, desc_rd}, 0);
    chk(!done_local && !done_remote && !abort_ev, "R1 events", {done_local, done_remote, abort_ev}, 0);
    pulse_sync();
    chk(ccs == 1, "R3 sync", 64'(ccs), 1);

    for (int n = 1; n <= 4; n++) begin
      for (int rm = 0; rm < 2; rm++) begin
        logic [31:0] b = 32'h40 + 32'h80 * 32'(n - 1);
        build_ring(b, n, 1'b1);
        remote = rm[0];
        cur_base = b; cur_n = n; delay = (n + rm) % 3;
        pulse_sync();
        pulse_ptr(b, 32'h0);
        clr();
        pulse_bell();
        wait_idle();
        chk(n_xfer == n && xi == n, "R2 R6 lap1 transfers", 64'(n_xfer), 64'(n));
        chk(n_dl == 1, "R8 lap1 local done", 64'(n_dl), 1);
        chk(n_dr == rm, "R9 lap1 remote done", 64'(n_dr), 64'(rm));
        chk(n_ab == 0 && !busy, "R5 lap1 parked", 64'(n_ab), 0);
        chk(ccs == 0, "R7 lap1 toggled", 64'(ccs), 0);
        build_ring(b, n, 1'b0);
        clr();
        pulse_bell();
        wait_idle();
        chk(n_xfer == n && xi == n, "R5 lap2 resume at head", 64'(n_xfer), 64'(n));
        chk(n_dl == 1 && n_dr == rm, "R8 R9 lap2 events", 64'(n_dl + n_dr), 64'(1 + rm));
        chk(ccs == 1, "R7 lap2 toggled", 64'(ccs), 1);
      end
    end

    // R5: head not owned
    remote = 0; delay = 1;
    build_ring(32'h300, 2, 1'b0);
    cur_base = 32'h300; cur_n = 2;
    pulse_sync();
    pulse_ptr(32'h300, 32'h0);
    clr();
    pulse_bell();
    wait_idle();
    chk(n_xfer == 0 && !busy, "R5 stall at head", 64'(n_xfer), 0);
    chk(ccs == 1, "R5 ccs kept", 64'(ccs), 1);
    build_ring(32'h300, 2, 1'b1);
    clr();
    pulse_bell();
    wait_idle();
    chk(n_xfer == 2 && ccs == 0, "R5 resume same element", 64'(n_xfer), 2);

    // R10: error on second element, error and done together
    build_ring(32'h200, 3, 1'b1);
    cur_base = 32'h200; cur_n = 3; delay = 0;
    pulse_sync();
    pulse_ptr(32'h200, 32'h0);
    clr();
    err_arm = 1; err_idx = 1;
    pulse_bell();
    wait_idle();
    chk(n_ab == 1 && n_dl == 0, "R10 abort only", 64'(n_ab), 1);
    chk(n_xfer == 2 && xi == 1 && !busy, "R10 stopped", 64'(n_xfer), 2);
    chk(ccs == 1, "R10 ccs kept", 64'(ccs), 1);
    n_xfer = 0; n_ab = 0;
    pulse_bell();
    wait_idle();
    chk(n_xfer == 2 && xi == 3 && n_dl == 1, "R10 resume failed element", 64'(n_xfer), 2);
    chk(n_ab == 0 && ccs == 0, "R10 clean resume", 64'(n_ab), 0);

    // R11 and R2: doorbell and pointer writes while busy
    build_ring(32'h380, 2, 1'b1);
    cur_base = 32'h380; cur_n = 2; delay = 20;
    pulse_sync();
    pulse_ptr(32'h380, 32'h0);
    clr();
    pulse_bell();
    repeat (4) @(negedge clk);
    pulse_ptr(32'h10, 32'h5);
    pulse_bell();
    wait_idle();
    chk(n_xfer == 2 && ccs == 0, "R11 lap unaffected", 64'(n_xfer), 2);
    build_ring(32'h380, 2, 1'b0);
    clr(); delay = 0;
    pulse_bell();
    wait_idle();
    chk(n_xfer == 2 && xi == 2, "R2 busy ptr write ignored", 64'(n_xfer), 2);

    summary();
    $finish;
  end
endmodule